// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block takes a bank of external interrupt lines and turns each qualifying event on them into a single delivery message. A message carries an 8-bit vector, an 8-bit destination identifier and a flag for the destination addressing mode. Every input has its own redirection entry. The entry chooses edge or level sensing, the active polarity and a mask bit, and it supplies the vector and destination fields. The block synchronises each line with two flops before it looks at the line. Edge events are stored in a pending bit until they are sent. A level-sensed input that has been sent sets an in-service flag, and the input is not sent again until an end-of-interrupt notice with the same vector clears that flag.

Software reaches the configuration through a two-location window. Offset 0x00 holds a selector, and offset 0x10 reads or writes the internal word that the selector points at. Behind the window are an identification word, a read-only capability word that reports the highest entry number, and two words per entry. When several inputs want service at once, the lowest-numbered one wins. The winning message is presented on a valid/ready port and stays unchanged until the port accepts it.

Top module: `intr_redirect`

## Requirements
- R1: After reset, msg_valid is 0, the selector reads 0, every entry's low word reads 0x00010000 (masked, all else zero) and every high word reads 0. The identification word reads ID_RESET in bits 27:24.
- R2: A write at cfg_addr 0x00 sets the 8-bit selector, which reads back in bits 7:0 with the other bits zero. A read or write at cfg_addr 0x10 accesses the selected internal word. Every other offset reads 0, and writes to it change nothing.
- R3: Internal word 0x00 (identification) keeps a writable 4-bit ID in bits 27:24. All its other bits read 0.
- R4: Internal word 0x01 (capability) reads NUM_INPUTS-1 in bits 23:16 and VERSION in bits 7:0, with all other bits 0. Writes to it have no effect.
- R5: Entry n occupies internal word 0x10+2n (low) and 0x11+2n (high). The low word stores vector in 7:0, logical mode in 11, active-low in 13, level in 15 and mask in 16, and shows the read-only in-service flag in 14. The high word stores the destination in 31:24. Every other bit reads 0, and selector values outside 0x00, 0x01 and the table read 0.
- R6: For an unmasked edge entry, each inactive-to-active transition of its input produces exactly one message. The message carries the entry's vector in msg_vector, its destination in msg_dest and bit 11 in msg_logical. Holding the input active produces nothing further.
- R7: With bit 13 set, a high-to-low transition is the active transition, and a low-to-high transition produces no message.
- R8: A masked entry produces no message. Edges that arrive while the entry is masked are discarded and are not delivered after it is unmasked.
- R9: An unmasked level entry whose input is active is delivered once and sets bit 14. It is not delivered again until eoi_valid arrives with eoi_vector equal to its vector, which clears bit 14. If the input is still active at that point, it is delivered again. An end-of-interrupt notice with a different vector has no effect.
- R10: When several inputs are requesting in the same cycle, the lowest-numbered input is delivered first.
- R11: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and msg_vector, msg_dest and msg_logical do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration window |
| cfg_addr | input | 5 | Byte offset in the window (0x00 selector, 0x10 data) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| irq_in | input | NUM_INPUTS | Asynchronous interrupt lines |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector that the notice retires |
| msg_valid | output | 1 | Delivery message present |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Vector of the message |
| msg_dest | output | 8 | Destination identifier of the message |
| msg_logical | output | 1 | 1 for logical addressing, 0 for physical |

## Verification
The bench uses the default NUM_INPUTS of 24. With that size it can reach the last entry (words 0x3E and 0x3F) and the first selector value past the table (0x40), so the table-bound decode is tested at both ends. ID_RESET is set to 5 rather than left at zero, so the reset check can tell the reset ID apart from an uncleared register. VERSION stays at its default of 0x20, and the capability word is expected to read 0x00170020.

// File: rtl/irc_pkg.sv
package irc_pkg;

  typedef struct packed {
    logic       mask;
    logic       level;
    logic       rirr;
    logic       low_act;
    logic       logical;
    logic [7:0] vector;
    logic [7:0] dest;
  } irc_entry_t;

  localparam logic [4:0] OFS_SEL  = 5'h00;
  localparam logic [4:0] OFS_DATA = 5'h10;
  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_TAB  = 8'h10;

  function automatic irc_entry_t reset_entry();
    irc_entry_t e;
    e      = '0;
    e.mask = 1'b1;
    return e;
  endfunction

  function automatic logic [31:0] low_word(irc_entry_t e);
    logic [31:0] w;
    w       = '0;
    w[7:0]  = e.vector;
    w[11]   = e.logical;
    w[13]   = e.low_act;
    w[14]   = e.rirr;
    w[15]   = e.level;
    w[16]   = e.mask;
    return w;
  endfunction

  function automatic logic [31:0] high_word(irc_entry_t e);
    return {e.dest, 24'h0};
  endfunction

  function automatic logic [31:0] version_word(int unsigned n, logic [7:0] ver);
    logic [7:0] top_idx;
    top_idx = 8'(n - 1);
    return {8'h00, top_idx, 8'h00, ver};
  endfunction

endpackage

// File: rtl/irc_regfile.sv
module irc_regfile
  import irc_pkg::*;
#(
  parameter int unsigned NUM_INPUTS = 24,
  parameter logic [3:0]  ID_RESET   = 4'h0,
  parameter logic [7:0]  VERSION    = 8'h20,
  localparam int unsigned IDX_W     = $clog2(NUM_INPUTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [4:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             grant_fire,
  input  logic [IDX_W-1:0] grant_idx,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vector,
  output irc_entry_t       entries_o [NUM_INPUTS]
);

  localparam int unsigned TAB_END = 16 + 2 * NUM_INPUTS;

  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  irc_entry_t       ent_q [NUM_INPUTS];
  logic [7:0]       rel;
  logic             in_tab;
  logic             hi_half;
  logic [IDX_W-1:0] ent_sel;
  logic             wr_data;
  logic [31:0]      data_word;

  assign rel     = sel_q - IDX_TAB;
  assign in_tab  = (int'(sel_q) >= 16) && (int'(sel_q) < int'(TAB_END));
  assign hi_half = rel[0];
  assign ent_sel = rel[IDX_W:1];
  assign wr_data = cfg_wr && (cfg_addr == OFS_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= ID_RESET;
      for (int i = 0; i < int'(NUM_INPUTS); i++) ent_q[i] <= reset_entry();
    end else begin
      if (cfg_wr && cfg_addr == OFS_SEL) sel_q <= cfg_wdata[7:0];
      if (wr_data && sel_q == IDX_ID) id_q <= cfg_wdata[27:24];
      for (int i = 0; i < int'(NUM_INPUTS); i++) begin
        if (wr_data && in_tab && ent_sel == IDX_W'(i)) begin
          if (hi_half) begin
            ent_q[i].dest <= cfg_wdata[31:24];
          end else begin
            ent_q[i].vector  <= cfg_wdata[7:0];
            ent_q[i].logical <= cfg_wdata[11];
            ent_q[i].low_act <= cfg_wdata[13];
            ent_q[i].level   <= cfg_wdata[15];
            ent_q[i].mask    <= cfg_wdata[16];
          end
        end
        if (grant_fire && grant_idx == IDX_W'(i) && ent_q[i].level)
          ent_q[i].rirr <= 1'b1;
        else if (eoi_valid && ent_q[i].level && eoi_vector == ent_q[i].vector)
          ent_q[i].rirr <= 1'b0;
      end
    end
  end

  always_comb begin
    data_word = '0;
    if (sel_q == IDX_ID)       data_word = {4'h0, id_q, 24'h0};
    else if (sel_q == IDX_VER) data_word = version_word(NUM_INPUTS, VERSION);
    else if (in_tab)           data_word = hi_half ? high_word(ent_q[ent_sel])
                                                   : low_word(ent_q[ent_sel]);
  end

  always_comb begin
    case (cfg_addr)
      OFS_SEL:  cfg_rdata = {24'h0, sel_q};
      OFS_DATA: cfg_rdata = data_word;
      default:  cfg_rdata = '0;
    endcase
  end

  assign entries_o = ent_q;

endmodule

// File: rtl/irc_input_stage.sv
module irc_input_stage #(
  parameter int unsigned NUM_INPUTS = 24,
  localparam int unsigned IDX_W     = $clog2(NUM_INPUTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_INPUTS-1:0] irq_in,
  input  logic [NUM_INPUTS-1:0] mask_vec,
  input  logic [NUM_INPUTS-1:0] level_vec,
  input  logic [NUM_INPUTS-1:0] lowact_vec,
  input  logic [NUM_INPUTS-1:0] rirr_vec,
  input  logic                  grant_fire,
  input  logic [IDX_W-1:0]      grant_idx,
  output logic [NUM_INPUTS-1:0] req_vec,
  output logic [NUM_INPUTS-1:0] pend_vec
);

  for (genvar g = 0; g < int'(NUM_INPUTS); g++) begin : g_line
    logic s1, s2, prev_act, pend;
    logic act, rise, taken;

    assign act   = s2 ^ lowact_vec[g];
    assign rise  = act && !prev_act;
    assign taken = grant_fire && (grant_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1       <= 1'b0;
        s2       <= 1'b0;
        prev_act <= 1'b0;
        pend     <= 1'b0;
      end else begin
        s1       <= irq_in[g];
        s2       <= s1;
        prev_act <= act;
        if (mask_vec[g] || level_vec[g]) pend <= 1'b0;
        else if (rise)                   pend <= 1'b1;
        else if (taken)                  pend <= 1'b0;
      end
    end

    assign req_vec[g]  = !mask_vec[g] && (level_vec[g] ? (act && !rirr_vec[g]) : pend);
    assign pend_vec[g] = pend;
  end

endmodule

// File: rtl/irc_arbiter.sv
module irc_arbiter #(
  parameter int unsigned NUM_INPUTS = 24,
  localparam int unsigned IDX_W     = $clog2(NUM_INPUTS)
) (
  input  logic [NUM_INPUTS-1:0] req_vec,
  output logic                  any_req,
  output logic [IDX_W-1:0]      win_idx
);

  function automatic logic [IDX_W-1:0] lowest_set(logic [NUM_INPUTS-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = int'(NUM_INPUTS) - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign any_req = |req_vec;
  assign win_idx = lowest_set(req_vec);

endmodule

// File: rtl/intr_redirect.sv
module intr_redirect
  import irc_pkg::*;
#(
  parameter int unsigned NUM_INPUTS = 24,
  parameter logic [3:0]  ID_RESET   = 4'h0,
  parameter logic [7:0]  VERSION    = 8'h20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [4:0]            cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  input  logic [NUM_INPUTS-1:0] irq_in,
  input  logic                  eoi_valid,
  input  logic [7:0]            eoi_vector,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [7:0]            msg_vector,
  output logic [7:0]            msg_dest,
  output logic                  msg_logical
);

  localparam int unsigned IDX_W = $clog2(NUM_INPUTS);

  irc_entry_t            entries [NUM_INPUTS];
  logic [NUM_INPUTS-1:0] mask_vec, level_vec, lowact_vec, rirr_vec;
  logic [NUM_INPUTS-1:0] req_vec, pend_vec;
  logic                  any_req;
  logic [IDX_W-1:0]      grant_idx;
  logic                  grant_fire;

  for (genvar g = 0; g < int'(NUM_INPUTS); g++) begin : g_unpack
    assign mask_vec[g]   = entries[g].mask;
    assign level_vec[g]  = entries[g].level;
    assign lowact_vec[g] = entries[g].low_act;
    assign rirr_vec[g]   = entries[g].rirr;
  end

  assign grant_fire = any_req && (!msg_valid || msg_ready);

  irc_regfile #(.NUM_INPUTS(NUM_INPUTS), .ID_RESET(ID_RESET), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .grant_fire(grant_fire),
    .grant_idx(grant_idx), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .entries_o(entries)
  );

  irc_input_stage #(.NUM_INPUTS(NUM_INPUTS)) u_inputs (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_vec(mask_vec),
    .level_vec(level_vec), .lowact_vec(lowact_vec), .rirr_vec(rirr_vec),
    .grant_fire(grant_fire), .grant_idx(grant_idx), .req_vec(req_vec),
    .pend_vec(pend_vec)
  );

  irc_arbiter #(.NUM_INPUTS(NUM_INPUTS)) u_arb (
    .req_vec(req_vec), .any_req(any_req), .win_idx(grant_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid   <= 1'b0;
      msg_vector  <= '0;
      msg_dest    <= '0;
      msg_logical <= 1'b0;
    end else if (grant_fire) begin
      msg_valid   <= 1'b1;
      msg_vector  <= entries[grant_idx].vector;
      msg_dest    <= entries[grant_idx].dest;
      msg_logical <= entries[grant_idx].logical;
    end else if (msg_ready) begin
      msg_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/irc_chk.sv
module irc_chk #(
  parameter int unsigned NUM_INPUTS = 24,
  localparam int unsigned IDX_W     = $clog2(NUM_INPUTS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  msg_valid,
  input logic                  msg_ready,
  input logic [7:0]            msg_vector,
  input logic [7:0]            msg_dest,
  input logic                  msg_logical,
  input logic                  grant_fire,
  input logic [IDX_W-1:0]      grant_idx,
  input logic [NUM_INPUTS-1:0] req_vec,
  input logic [NUM_INPUTS-1:0] mask_vec,
  input logic [NUM_INPUTS-1:0] level_vec,
  input logic [NUM_INPUTS-1:0] rirr_vec
);

  logic below_req;
  always_comb begin
    below_req = 1'b0;
    for (int i = 0; i < int'(NUM_INPUTS); i++)
      if (IDX_W'(i) < grant_idx && req_vec[i]) below_req = 1'b1;
  end

  // R11
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest)
                                && $stable(msg_logical));

  // R8
  grant_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> !mask_vec[grant_idx]);

  // R6
  grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> req_vec[grant_idx]);

  // R9
  rirr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire && level_vec[grant_idx] |-> !rirr_vec[grant_idx]);

  // R9
  rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire && level_vec[grant_idx] |=> rirr_vec[$past(grant_idx)]);

  // R10
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> !below_req);

endmodule

bind intr_redirect irc_chk #(.NUM_INPUTS(NUM_INPUTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_logical(msg_logical),
  .grant_fire(grant_fire), .grant_idx(grant_idx), .req_vec(req_vec),
  .mask_vec(mask_vec), .level_vec(level_vec), .rirr_vec(rirr_vec)
);

// File: tb/intr_redirect_bench.sv
module intr_redirect_bench;

  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [N-1:0] irq_in = '0;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [7:0]  msg_vector, msg_dest;
  logic        msg_logical;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [16:0] exp_q [$];
  logic [16:0] held;
  bit          hold_seen = 0;

  always #2.5 clk = ~clk;

  intr_redirect #(.NUM_INPUTS(N), .ID_RESET(4'h5)) u_intr_redirect (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_in(irq_in),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest),
    .msg_logical(msg_logical)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic rd_word(logic [7:0] idx, output logic [31:0] d);
    wr(5'h00, {24'h0, idx});
    rd(5'h10, d);
  endtask

  task automatic set_entry(int n, logic [31:0] lo, logic [7:0] dst);
    wr(5'h00, 32'(16 + 2 * n));
    wr(5'h10, lo);
    wr(5'h00, 32'(17 + 2 * n));
    wr(5'h10, {dst, 24'h0});
  endtask

  task automatic expect_msg(logic lg, logic [7:0] v, logic [7:0] d);
    exp_q.push_back({lg, v, d});
  endtask

  task automatic drained(string req);
    step(30);
    check(exp_q.size() == 0, req, 32'(exp_q.size()), 32'h0);
  endtask

  task automatic eoi(logic [7:0] v);
    @(posedge clk); #1;
    eoi_valid = 1'b1; eoi_vector = v;
    @(posedge clk); #1;
    eoi_valid = 1'b0;
  endtask

  // Scoreboard monitor: compares each accepted message with the queue head (R6 R11)
  always @(negedge clk) begin
    if (rst_n && msg_valid) begin
      if (!msg_ready) begin
        if (hold_seen)
          check({msg_logical, msg_vector, msg_dest} == held, "R11 hold",
                32'({msg_logical, msg_vector, msg_dest}), 32'(held));
        held = {msg_logical, msg_vector, msg_dest};
        hold_seen = 1;
      end else begin
        hold_seen = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected message", 32'({msg_logical, msg_vector, msg_dest}), 32'h0);
        end else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          check({msg_logical, msg_vector, msg_dest} == e, "R6 message content",
                32'({msg_logical, msg_vector, msg_dest}), 32'(e));
        end
      end
    end else begin
      hold_seen = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    step(4);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    check(msg_valid == 1'b0, "R1 msg_valid", 32'(msg_valid), 32'h0);
    rd(5'h00, d);         check(d == 32'h0, "R1 selector", d, 32'h0);
    rd(5'h10, d);         check(d == 32'h0500_0000, "R1 id reset", d, 32'h0500_0000);
    rd_word(8'h10, d);    check(d == 32'h0001_0000, "R1 entry0 low", d, 32'h0001_0000);
    rd_word(8'h3F, d);    check(d == 32'h0, "R1 entry23 high", d, 32'h0);

    // R4 capability word, read only
    rd_word(8'h01, d);    check(d == 32'h0017_0020, "R4 version", d, 32'h0017_0020);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, d);         check(d == 32'h0017_0020, "R4 write ignored", d, 32'h0017_0020);

    // R3 identification field width
    wr(5'h00, 32'h0);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, d);         check(d == 32'h0F00_0000, "R3 id field", d, 32'h0F00_0000);

    // R2 selector readback and dead offsets
    wr(5'h00, 32'hFFFF_FF3E);
    rd(5'h00, d);         check(d == 32'h0000_003E, "R2 selector bits", d, 32'h3E);
    wr(5'h08, 32'h0000_0001);
    rd(5'h00, d);         check(d == 32'h0000_003E, "R2 other offset write", d, 32'h3E);
    rd(5'h08, d);         check(d == 32'h0, "R2 other offset read", d, 32'h0);

    // R5 field layout and decode bounds
    wr(5'h00, 32'h14);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, d);         check(d == 32'h0001_A8FF, "R5 low word bits", d, 32'h0001_A8FF);
    wr(5'h00, 32'h15);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, d);         check(d == 32'hFF00_0000, "R5 high word bits", d, 32'hFF00_0000);
    set_entry(2, 32'h0001_0000, 8'h00);
    rd_word(8'h40, d);    check(d == 32'h0, "R5 past table", d, 32'h0);
    rd_word(8'h02, d);    check(d == 32'h0, "R5 unused index", d, 32'h0);
    set_entry(23, 32'h0001_0077, 8'h99);
    rd_word(8'h3E, d);    check(d == 32'h0001_0077, "R5 last entry low", d, 32'h0001_0077);
    rd_word(8'h3F, d);    check(d == 32'h9900_0000, "R5 last entry high", d, 32'h9900_0000);

    // R6 edge, logical mode
    set_entry(3, 32'h0000_0833, 8'h04);
    expect_msg(1'b1, 8'h33, 8'h04);
    irq_in[3] = 1'b1;
    drained("R6 single edge delivered once");
    irq_in[3] = 1'b0;
    step(5);
    expect_msg(1'b1, 8'h33, 8'h04);
    irq_in[3] = 1'b1;
    drained("R6 second edge");
    irq_in[3] = 1'b0;

    // R6 edge, physical mode on another input
    set_entry(20, 32'h0000_0054, 8'hA0);
    expect_msg(1'b0, 8'h54, 8'hA0);
    irq_in[20] = 1'b1; step(3); irq_in[20] = 1'b0;
    drained("R6 physical mode");

    // R7 active-low
    irq_in[5] = 1'b1;
    step(5);
    set_entry(5, 32'h0000_2035, 8'h06);
    step(5);
    check(exp_q.size() == 0, "R7 idle high no event", 32'(exp_q.size()), 32'h0);
    expect_msg(1'b0, 8'h35, 8'h06);
    irq_in[5] = 1'b0;
    drained("R7 falling edge");
    irq_in[5] = 1'b1;
    drained("R7 rising edge ignored");

    // R8 mask
    set_entry(7, 32'h0001_0037, 8'h08);
    irq_in[7] = 1'b1; step(4); irq_in[7] = 1'b0; step(4);
    set_entry(7, 32'h0000_0037, 8'h08);
    drained("R8 masked edge discarded");

    // R9 level with in-service flag
    set_entry(9, 32'h0000_8049, 8'h0A);
    expect_msg(1'b0, 8'h49, 8'h0A);
    irq_in[9] = 1'b1;
    drained("R9 level delivered once");
    rd_word(8'h22, d);    check(d == 32'h0000_C049, "R9 flag set", d, 32'h0000_C049);
    eoi(8'h50);
    drained("R9 other vector no effect");
    rd_word(8'h22, d);    check(d == 32'h0000_C049, "R9 flag kept", d, 32'h0000_C049);
    expect_msg(1'b0, 8'h49, 8'h0A);
    eoi(8'h49);
    drained("R9 redelivery after eoi");
    irq_in[9] = 1'b0;
    step(5);
    eoi(8'h49);
    drained("R9 inactive after eoi");
    rd_word(8'h22, d);    check(d == 32'h0000_8049, "R9 flag cleared", d, 32'h0000_8049);

    // R10 arbitration with R11 backpressure
    set_entry(10, 32'h0000_003A, 8'h0B);
    set_entry(14, 32'h0000_003E, 8'h0F);
    msg_ready = 1'b0;
    expect_msg(1'b0, 8'h3A, 8'h0B);
    expect_msg(1'b0, 8'h3E, 8'h0F);
    irq_in[14] = 1'b1; irq_in[10] = 1'b1;
    step(15);
    check(msg_valid == 1'b1, "R11 valid held", 32'(msg_valid), 32'h1);
    check(msg_vector == 8'h3A, "R10 lowest first", 32'(msg_vector), 32'h3A);
    msg_ready = 1'b1;
    drained("R10 both delivered");
    irq_in[14] = 1'b0; irq_in[10] = 1'b0;
    step(5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule